// File: doc/BRIEF.md
# Misaligned Access Splitter with Byte Enables

This block sits between an internal bus master and an external memory bus. A requester hands it one read or write of 1, 2, 3 or 4 bytes at any byte address. The block cuts that request into a short sequence of naturally aligned external accesses and drives active-low byte-write enables for each one. When every piece has been acknowledged, it returns a single response. The external port may be 32 bits wide (four byte lanes) or 16 bits wide (two byte lanes), chosen by a static control pin. Read bytes from all pieces are collected in a holding register and returned together in big-endian operand order.

A second, independent path checks requests that arrive from an external master. An aligned request is forwarded to the internal side. A misaligned one raises a transfer-error flag and is not forwarded.

The request, response and external access channels use valid/ready handshakes. A request is taken only in a cycle where `req_ready` is high, and `req_ready` is high only while no transfer is in flight. `rsp_valid` stays high, with `rsp_rdata` and `rsp_err` held steady, until `rsp_ready` is seen. `ext_valid` stays high, with address, size, enables and write data held, until the cycle in which `ext_ready` is high. `ext_err` is sampled only in that cycle. `port16` must stay constant while a transfer is in flight.

Top module: `unaligned_splitter`

## Requirements
- R1: Every external access is naturally aligned. `ext_size` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. A 2-byte access has `ext_addr[0]`=0, and a 4-byte access has `ext_addr[1:0]`=0.
- R2: Pieces are issued in ascending address order, and each piece waits for `ext_ready` before the next one starts. The splitting rule on a 32-bit port is: if the offset is 0 and 3 or more bytes remain, issue a word; if the offset is 1 and 3 or more bytes remain, issue a word covering lanes 1..3; if the offset is even and 2 or more bytes remain, issue a halfword; otherwise issue a byte. On a 16-bit port the rule is: if the address is even and 2 or more bytes remain, issue a halfword; otherwise issue a byte. Exactly one response follows the last piece.
- R3: A 3-byte piece is issued as a 4-byte access in which the enable of the excluded lane is held high. `ext_be_n` is 4'b1000 when the piece starts at offset 0, and 4'b0001 when it starts at offset 1.
- R4: Lane i is carried on `ext_wdata`/`ext_rdata` bits [31-8i -: 8] and enabled by `ext_be_n[i]`. Lane 0 is the most significant byte. On a 32-bit port, a byte at word offset o uses lane o, and a halfword uses lanes 0-1 or 2-3, selected by address bit 1.
- R5: With `port16`=1, only lanes 0 and 1 are used. `ext_be_n[3:2]` stays 2'b11, no 4-byte access is issued, and a byte uses lane `addr[0]`.
- R6: A read returns its operand right-justified in `rsp_rdata`, with the lowest-addressed byte as the most significant. The upper bits are zero. The data is valid only while `rsp_valid` is high.
- R7: If `ext_err` is high together with `ext_ready`, no further piece is issued, and the response carries `rsp_err`=1.
- R8: On the external-master path, `xm_len` holds the byte count minus 1. `xm_tea` is raised for any of these cases: a 3-byte size; a 2-byte access with `addr[0]`=1; a 4-byte access with `addr[1:0]`≠0; a burst (`xm_burst`=1) with `addr[2:0]`≠0. Otherwise `xm_fwd` is raised. The two are never high together, and both stay low without `xm_valid`.
- R9: While held, the response and external access channels keep their payload stable, and `req_ready` is low from acceptance until the response is taken.
- R10: A write changes exactly the addressed bytes, and each byte receives its operand byte in big-endian order. Lanes whose enable is inactive are driven 0.
- R11: After reset, `req_ready`=1, `ext_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| port16 | input | 1 | 1 selects a 16-bit external port |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | request accepted this cycle when high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | byte address of the operand |
| req_len | input | 2 | byte count minus 1 |
| req_wdata | input | 32 | write operand, right-justified |
| rsp_valid | output | 1 | response available |
| rsp_ready | input | 1 | response taken |
| rsp_rdata | output | 32 | read operand, right-justified |
| rsp_err | output | 1 | transfer ended by an external error |
| ext_valid | output | 1 | external access in progress |
| ext_ready | input | 1 | external access acknowledged |
| ext_err | input | 1 | acknowledged access failed |
| ext_write | output | 1 | external access direction |
| ext_addr | output | ADDR_W | aligned external address |
| ext_size | output | 2 | 0 byte, 1 halfword, 2 word |
| ext_be_n | output | 4 | active-low lane enables |
| ext_wdata | output | 32 | lane-steered write data |
| ext_rdata | input | 32 | lane read data |
| xm_valid | input | 1 | external-master request present |
| xm_burst | input | 1 | external-master request is a burst |
| xm_addr | input | ADDR_W | external-master address |
| xm_len | input | 2 | external-master byte count minus 1 |
| xm_fwd | output | 1 | request forwarded inward |
| xm_tea | output | 1 | transfer error for a misaligned request |

## Verification
The assertions check the following on every cycle:
- alignment of every external access against its size;
- the absence of 4-byte accesses and upper lanes on a 16-bit port;
- the enable patterns allowed for 4-byte accesses;
- that the splitter goes quiet after an error acknowledge;
- payload stability on held channels;
- mutual exclusion of the forward and error flags.

Only the bench scenarios can show the following:
- that the pieces of a request cover exactly the requested bytes, in the right count;
- that each operand byte lands at the right address;
- that read data is reassembled in big-endian order;
- that an error part-way through a split leaves the later pieces unissued.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2
  } esz_e;

  typedef struct packed {
    logic [2:0] nbytes;  // bytes of the operand carried by this piece
    logic [1:0] lane;    // first lane used
    esz_e       sz;      // access size on the bus
    logic [3:0] be_n;    // active-low lane enables
  } piece_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } st_e;
endpackage

// File: rtl/xs_piece_plan.sv
module xs_piece_plan
  import xs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        remain,
  input  logic              port16,
  output piece_t            pc,
  output logic [ADDR_W-1:0] bus_addr
);
  logic [1:0] ofs;
  assign ofs = cur_addr[1:0];

  always_comb begin
    pc       = '{nbytes: 3'd1, lane: ofs, sz: ESZ_BYTE, be_n: ~(4'b0001 << ofs)};
    bus_addr = cur_addr;
    if (port16) begin
      // two lanes only; address bit 1 never picks a lane
      if (!cur_addr[0] && remain >= 3'd2)
        pc = '{nbytes: 3'd2, lane: 2'd0, sz: ESZ_HALF, be_n: 4'b1100};
      else if (cur_addr[0])
        pc = '{nbytes: 3'd1, lane: 2'd1, sz: ESZ_BYTE, be_n: 4'b1101};
      else
        pc = '{nbytes: 3'd1, lane: 2'd0, sz: ESZ_BYTE, be_n: 4'b1110};
    end else begin
      if (ofs == 2'd0 && remain >= 3'd3) begin
        bus_addr = {cur_addr[ADDR_W-1:2], 2'b00};
        if (remain >= 3'd4)
          pc = '{nbytes: 3'd4, lane: 2'd0, sz: ESZ_WORD, be_n: 4'b0000};
        else
          pc = '{nbytes: 3'd3, lane: 2'd0, sz: ESZ_WORD, be_n: 4'b1000};
      end else if (ofs == 2'd1 && remain >= 3'd3) begin
        bus_addr = {cur_addr[ADDR_W-1:2], 2'b00};
        pc = '{nbytes: 3'd3, lane: 2'd1, sz: ESZ_WORD, be_n: 4'b0001};
      end else if (!ofs[0] && remain >= 3'd2) begin
        pc = '{nbytes: 3'd2, lane: ofs, sz: ESZ_HALF,
               be_n: ofs[1] ? 4'b0011 : 4'b1100};
      end
    end
  end
endmodule

// File: rtl/xs_wsteer.sv
module xs_wsteer
  import xs_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        len,
  input  logic [2:0]        done,
  input  piece_t            pc,
  output logic [DATA_W-1:0] lane_data
);
  logic [BYTE_W-1:0] op [LANES];

  // operand byte k (k=0 most significant) from the right-justified word
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      op[k] = '0;
      if (k < int'(len)) op[k] = wdata[BYTE_W*(int'(len)-1-k) +: BYTE_W];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      int rel;
      int k;
      rel = i - int'(pc.lane);
      k   = int'(done) + rel;
      lane_data[DATA_W-1-BYTE_W*i -: BYTE_W] = '0;
      if (rel >= 0 && rel < int'(pc.nbytes) && k < LANES)
        lane_data[DATA_W-1-BYTE_W*i -: BYTE_W] = op[k];
    end
  end
endmodule

// File: rtl/xs_rgather.sv
module xs_rgather
  import xs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic [2:0]        done,
  input  piece_t            pc,
  input  logic [2:0]        len,
  input  logic [DATA_W-1:0] lane_in,
  output logic [DATA_W-1:0] operand
);
  logic [BYTE_W-1:0] hold [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < LANES; k++) hold[k] <= '0;
    end else if (cap) begin
      for (int j = 0; j < LANES; j++) begin
        if (j < int'(pc.nbytes) && int'(done) + j < LANES && int'(pc.lane) + j < LANES)
          hold[int'(done) + j] <= lane_in[DATA_W-1-BYTE_W*(int'(pc.lane)+j) -: BYTE_W];
      end
    end
  end

  always_comb begin
    operand = '0;
    for (int k = 0; k < LANES; k++)
      if (k < int'(len)) operand[BYTE_W*(int'(len)-1-k) +: BYTE_W] = hold[k];
  end
endmodule

// File: rtl/xs_xm_check.sv
module xs_xm_check #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xm_valid,
  input  logic              xm_burst,
  input  logic [ADDR_W-1:0] xm_addr,
  input  logic [1:0]        xm_len,
  output logic              xm_fwd,
  output logic              xm_tea
);
  logic size_ok;
  logic ok;

  always_comb begin
    case (xm_len)
      2'd0:    size_ok = 1'b1;
      2'd1:    size_ok = !xm_addr[0];
      2'd3:    size_ok = xm_addr[1:0] == 2'b00;
      default: size_ok = 1'b0;
    endcase
    ok = size_ok && (!xm_burst || xm_addr[2:0] == 3'b000);
  end

  assign xm_fwd = xm_valid && ok;
  assign xm_tea = xm_valid && !ok;

  p_fwd_tea_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xm_fwd && xm_tea));
  p_fwd_word_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xm_fwd && xm_len == 2'd3 |-> xm_addr[1:0] == 2'b00);
  p_fwd_burst_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xm_fwd && xm_burst |-> xm_addr[2:0] == 3'b000);
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xm_valid |-> !xm_fwd && !xm_tea);
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import xs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port16,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              ext_valid,
  input  logic              ext_ready,
  input  logic              ext_err,
  output logic              ext_write,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [1:0]        ext_size,
  output logic [3:0]        ext_be_n,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  input  logic              xm_valid,
  input  logic              xm_burst,
  input  logic [ADDR_W-1:0] xm_addr,
  input  logic [1:0]        xm_len,
  output logic              xm_fwd,
  output logic              xm_tea
);
  st_e               st;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        len_q;
  logic [2:0]        done_q;
  logic              wr_q;
  logic              p16_q;
  logic              err_q;
  logic [31:0]       wdata_q;
  logic [2:0]        remain;
  piece_t            pc;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       steer;
  logic [31:0]       gathered;
  logic              accept;
  logic              fin;
  logic [2:0]        done_nx;

  assign req_ready = st == ST_IDLE;
  assign accept    = req_valid && req_ready;
  assign remain    = len_q - done_q;
  assign fin       = st == ST_BUSY && ext_ready;
  assign done_nx   = done_q + pc.nbytes;

  xs_piece_plan #(.ADDR_W(ADDR_W)) u_plan (
    .cur_addr(cur_addr), .remain(remain), .port16(p16_q),
    .pc(pc), .bus_addr(bus_addr)
  );

  xs_wsteer u_steer (
    .wdata(wdata_q), .len(len_q), .done(done_q), .pc(pc), .lane_data(steer)
  );

  xs_rgather u_gather (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .cap(fin && !ext_err && !wr_q),
    .done(done_q), .pc(pc), .len(len_q),
    .lane_in(ext_rdata), .operand(gathered)
  );

  xs_xm_check #(.ADDR_W(ADDR_W)) u_xm (
    .clk(clk), .rst_n(rst_n), .xm_valid(xm_valid), .xm_burst(xm_burst),
    .xm_addr(xm_addr), .xm_len(xm_len), .xm_fwd(xm_fwd), .xm_tea(xm_tea)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      len_q    <= '0;
      done_q   <= '0;
      wr_q     <= 1'b0;
      p16_q    <= 1'b0;
      err_q    <= 1'b0;
      wdata_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          cur_addr <= req_addr;
          len_q    <= {1'b0, req_len} + 3'd1;
          done_q   <= '0;
          wr_q     <= req_write;
          p16_q    <= port16;
          err_q    <= 1'b0;
          wdata_q  <= req_wdata;
          st       <= ST_BUSY;
        end
        ST_BUSY: if (ext_ready) begin
          if (ext_err) begin
            err_q <= 1'b1;
            st    <= ST_RESP;
          end else begin
            done_q   <= done_nx;
            cur_addr <= cur_addr + ADDR_W'(pc.nbytes);
            if (done_nx >= len_q) st <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ext_valid = st == ST_BUSY;
  assign ext_write = wr_q;
  assign ext_addr  = bus_addr;
  assign ext_size  = pc.sz;
  assign ext_be_n  = ext_valid ? pc.be_n : 4'hF;
  assign ext_wdata = (ext_valid && wr_q) ? steer : '0;
  assign rsp_valid = st == ST_RESP;
  assign rsp_rdata = rsp_valid ? gathered : '0;
  assign rsp_err   = rsp_valid && err_q;

  p_ext_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> ext_size != 2'd3
      && (ext_size != 2'd1 || !ext_addr[0])
      && (ext_size != 2'd2 || ext_addr[1:0] == 2'b00));
  p_rsp_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(ext_valid && ext_ready));
  p_word_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && ext_size == 2'd2 |->
      ext_be_n == 4'b0000 || ext_be_n == 4'b1000 || ext_be_n == 4'b0001);
  p_some_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> ext_be_n != 4'hF);
  p_port16_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && p16_q |-> ext_be_n[3:2] == 2'b11 && ext_size != 2'd2);
  p_abort_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && ext_ready && ext_err |=> !ext_valid && rsp_valid && rsp_err);
  p_ext_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr)
      && $stable(ext_be_n) && $stable(ext_wdata) && $stable(ext_size));
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ext_valid && !rsp_valid);
endmodule

// File: tb/test_unaligned_splitter.sv
module test_unaligned_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port16 = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic [31:0] rsp_rdata;
  logic        ext_valid, ext_ready = 1'b0, ext_err = 1'b0, ext_write;
  logic [31:0] ext_addr, ext_wdata, ext_rdata = '0;
  logic [1:0]  ext_size;
  logic [3:0]  ext_be_n;
  logic        xm_valid = 1'b0, xm_burst = 1'b0, xm_fwd, xm_tea;
  logic [31:0] xm_addr = '0;
  logic [1:0]  xm_len = '0;

  always #2 clk = ~clk;  // 250 MHz

  unaligned_splitter i_unaligned_splitter (.*);

  int tests = 0, fails = 0;
  logic [7:0] mem [32];
  int ext_delay = 0, err_piece = 0, pcount = 0, bad_align = 0, wcnt = 0;
  logic [3:0] first_be = 4'hF;
  logic finished = 1'b0;

  typedef struct packed {
    logic        p16;
    logic [4:0]  addr;
    logic [1:0]  len;
    logic [31:0] wdata;
    logic [1:0]  npc;
    logic [3:0]  be;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 5'd4,  2'd3, 32'h11223344, 2'd1, 4'b0000},
    '{1'b0, 5'd5,  2'd3, 32'hA1B2C3D4, 2'd2, 4'b0001},
    '{1'b0, 5'd8,  2'd2, 32'h00556677, 2'd1, 4'b1000},
    '{1'b0, 5'd7,  2'd3, 32'hCAFEF00D, 2'd2, 4'b0111},
    '{1'b0, 5'd6,  2'd3, 32'h0BADBEEF, 2'd2, 4'b0011},
    '{1'b0, 5'd9,  2'd1, 32'h00009876, 2'd2, 4'b1101},
    '{1'b0, 5'd10, 2'd0, 32'h000000E5, 2'd1, 4'b1011},
    '{1'b0, 5'd11, 2'd2, 32'h00ABCDEF, 2'd2, 4'b0111},
    '{1'b1, 5'd4,  2'd3, 32'h01020304, 2'd2, 4'b1100},
    '{1'b1, 5'd5,  2'd3, 32'hF1E2D3C4, 2'd3, 4'b1101},
    '{1'b1, 5'd6,  2'd2, 32'h00778899, 2'd2, 4'b1100},
    '{1'b1, 5'd7,  2'd0, 32'h0000005A, 2'd1, 4'b1101}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // external memory responder: lane i maps to base+i
  initial begin
    forever begin
      @(negedge clk);
      if (ext_ready) begin
        ext_ready = 1'b0;
        ext_err   = 1'b0;
        wcnt      = 0;
      end else if (ext_valid && rst_n) begin
        if (wcnt >= ext_delay) begin
          logic [4:0] base;
          pcount++;
          if (pcount == 1) first_be = ext_be_n;
          if ((ext_size == 2'd1 && ext_addr[0]) || (ext_size == 2'd2 && ext_addr[1:0] != 2'b00)
              || ext_size == 2'd3)
            bad_align++;
          base = port16 ? {ext_addr[4:1], 1'b0} : {ext_addr[4:2], 2'b00};
          if (err_piece == pcount) ext_err = 1'b1;
          else if (ext_write)
            for (int i = 0; i < 4; i++)
              if (!ext_be_n[i]) mem[base + 5'(i)] = ext_wdata[31-8*i -: 8];
          for (int i = 0; i < 4; i++) ext_rdata[31-8*i -: 8] = mem[base + 5'(i)];
          ext_ready = 1'b1;
        end else wcnt++;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [1:0] len,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
    int n;
    pcount = 0; bad_align = 0; first_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    rd = rsp_rdata;
    er = rsp_err;
    while (rsp_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 32; i++) mem[i] = 8'(8'h40 + i);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp_rd, mask;
    logic er;
    int n;
    bit ok;

    repeat (3) @(negedge clk);
    check(req_ready && !ext_valid && !rsp_valid, "R11 reset state",
          {29'b0, req_ready, ext_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;

    foreach (VEC[v]) begin
      n = int'(VEC[v].len) + 1;
      mask = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
      fill_mem();
      port16 = VEC[v].p16;
      ext_delay = (v % 2 == 1) ? 2 : 0;
      err_piece = 0;
      xfer(1'b1, {27'b0, VEC[v].addr}, VEC[v].len, VEC[v].wdata, rd, er);
      check(!er, "R7 no spurious error", {31'b0, er}, 0);
      check(pcount == int'(VEC[v].npc), "R2 piece count", pcount, VEC[v].npc);
      check(first_be == VEC[v].be, "R4 first piece enables", first_be, VEC[v].be);
      check(bad_align == 0, "R1 aligned pieces", bad_align, 0);
      if (VEC[v].p16)
        check(first_be[3:2] == 2'b11, "R5 upper lanes idle", first_be, VEC[v].be);
      if (VEC[v].be == 4'b1000 || VEC[v].be == 4'b0001)
        check(first_be == VEC[v].be, "R3 masked 3-byte piece", first_be, VEC[v].be);
      ok = 1'b1;
      for (int i = 0; i < 32; i++) begin
        logic [7:0] e;
        e = 8'(8'h40 + i);
        if (i >= int'(VEC[v].addr) && i < int'(VEC[v].addr) + n)
          e = VEC[v].wdata[8*(n-1-(i-int'(VEC[v].addr))) +: 8];
        if (mem[i] !== e) begin
          ok = 1'b0;
          check(1'b0, "R10 memory byte", {24'b0, mem[i]}, {24'b0, e});
        end
      end
      if (ok) check(1'b1, "R10 memory image", 0, 0);
      xfer(1'b0, {27'b0, VEC[v].addr}, VEC[v].len, 32'h0, rd, er);
      exp_rd = VEC[v].wdata & mask;
      check(rd == exp_rd, "R6 read reassembly", rd, exp_rd);
      check(pcount == int'(VEC[v].npc), "R2 read piece count", pcount, VEC[v].npc);
    end

    // error on first piece of a split: nothing more issued
    fill_mem(); port16 = 1'b0; ext_delay = 0; err_piece = 1;
    xfer(1'b1, 32'd7, 2'd3, 32'h99887766, rd, er);
    check(er, "R7 error reported", {31'b0, er}, 1);
    check(pcount == 1, "R7 later pieces abandoned", pcount, 1);
    check(mem[7] == 8'h47 && mem[8] == 8'h48, "R7 memory untouched",
          {mem[7], mem[8]}, 16'h4748);
    // error on second piece of a 16-bit three-piece split
    fill_mem(); port16 = 1'b1; err_piece = 2;
    xfer(1'b0, 32'd5, 2'd3, 32'h0, rd, er);
    check(er && pcount == 2, "R7 error mid split", pcount, 2);
    err_piece = 0;

    // response back-pressure
    fill_mem(); port16 = 1'b0; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'd2; req_len = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    rd = rsp_rdata;
    repeat (3) @(negedge clk);
    check(rsp_valid && !req_ready && rsp_rdata == rd, "R9 response held", rsp_rdata, rd);
    check(rd == 32'h00004243, "R6 halfword read", rd, 32'h00004243);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 released after ready",
          {30'b0, rsp_valid, req_ready}, 1);

    // external-master alignment checks
    begin
      logic [37:0] xv [9];  // burst, len, addr[7:0], expect tea, pad
      xv = '{ {1'b0, 2'd1, 8'd2, 1'b0, 26'd0}, {1'b0, 2'd1, 8'd1, 1'b1, 26'd0},
              {1'b0, 2'd2, 8'd4, 1'b1, 26'd0}, {1'b0, 2'd3, 8'd4, 1'b0, 26'd0},
              {1'b0, 2'd3, 8'd6, 1'b1, 26'd0}, {1'b0, 2'd0, 8'd3, 1'b0, 26'd0},
              {1'b1, 2'd3, 8'd8, 1'b0, 26'd0}, {1'b1, 2'd0, 8'd4, 1'b1, 26'd0},
              {1'b1, 2'd1, 8'd16, 1'b0, 26'd0} };
      foreach (xv[k]) begin
        @(negedge clk);
        xm_valid = 1'b1; xm_burst = xv[k][37]; xm_len = xv[k][36:35];
        xm_addr = {24'b0, xv[k][34:27]};
        #1;
        check(xm_tea == xv[k][26] && xm_fwd == !xv[k][26], "R8 external master check",
              {30'b0, xm_tea, xm_fwd}, {30'b0, xv[k][26], !xv[k][26]});
      end
      @(negedge clk);
      xm_valid = 1'b0;
      #1;
      check(!xm_tea && !xm_fwd, "R8 idle without valid", {30'b0, xm_tea, xm_fwd}, 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule